// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of a SPI controller from the system clock. One divide field is read under one of two laws, chosen by a mode bit. In the exponential law each half period of the serial clock lasts a power of two of system cycles. In the linear law each half period lasts the field value plus one cycle. Besides the serial clock level, the block gives the shift engine three single-cycle strobes: a toggle tick, a leading-edge strobe and a trailing-edge strobe. With these the engine can pick its launch and sample edges by clock phase without looking at the clock itself.

Mode, divide value and idle level are captured only while the enable input is low, and they stay frozen while it is high. Raising enable restarts the timing from zero, and the serial clock always leaves its idle level first. The fastest setting toggles the serial clock on every system cycle, so the edge rate equals the system clock rate.

Top module: `sclk_div_dual`

## Requirements
- R1: With the mode bit at 1 (linear), the half period is N+1 system cycles. Counting the first cycle with enable high as cycle 0, strobes fall in cycles (k+1)(N+1)-1 for k = 0, 1, 2, and so on.
- R2: With the mode bit at 0 (exponential) and N from 0 to 15, the half period is 2^N cycles. Strobes fall in cycles (k+1)·2^N-1.
- R3: In exponential mode, a divide value above 15 behaves exactly as 15.
- R4: With N = 0 in either mode, a strobe occurs in every enabled cycle and the serial clock flips on every system clock edge.
- R5: Mode, divide value and idle level are captured only on clock edges where enable is low. Changes made to these inputs while enable is high have no effect on the edge timing or on the levels.
- R6: While enable is low, all three strobes are low. From the cycle after a low-enable edge, the serial clock rests at the captured idle level.
- R7: The tick is high in exactly the cycle whose closing edge flips the serial clock. The leading strobe accompanies a tick while the clock is at its idle level, and the trailing strobe accompanies a tick while it is not. The two alternate, starting with the leading strobe.
- R8: Dropping enable in mid-period and raising it again restarts the timing. The first strobe again falls N+1 (linear) or 2^N (exponential) cycles after enable.
- R9: With the idle-level input at 1, the serial clock rests high and the leading edge is a falling edge.
- R10: After synchronous reset the serial clock and all strobes are low, and the captured settings are exponential mode, N = 0 and idle low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the divider; settings are captured while low |
| cfg_linear | input | 1 | Divide law: 1 linear, 0 exponential |
| cfg_div | input | 8 | Divide value N |
| cfg_idle_high | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock level |
| sclk_tick | output | 1 | High in the cycle before each serial clock flip |
| lead_stb | output | 1 | Tick that moves the clock away from idle |
| trail_stb | output | 1 | Tick that returns the clock to idle |

## Verification
The embedded assertions check several properties on every cycle. The captured settings stay frozen while enabled. Both counters restart from their start values when enable rises. The linear counter stays within its reload value. The serial clock rests at idle when disabled and holds between ticks. Each leading or trailing strobe moves the clock in the expected direction. Only the bench scenarios can show the exact edge cycles under each law, the clamping of large exponential values, the effect of changing settings in mid-run, and the restart after a partial period, because these depend on counted intervals across many cycles.

// File: rtl/sdiv_pkg.sv
// Package: shared widths and the captured-settings type for the serial
// clock divider. Assumes an 8-bit divide field and a 0..15 exponent range.
package sdiv_pkg;
    localparam int unsigned DIV_W     = 8;
    localparam int unsigned EXP_MAX   = 15;
    localparam int unsigned EXP_SEL_W = $clog2(EXP_MAX + 1);
    localparam int unsigned EXP_CNT_W = EXP_MAX;

    typedef struct packed {
        logic                 linear;
        logic                 idle_high;
        logic [DIV_W-1:0]     div;
        logic [EXP_SEL_W-1:0] exp_n;
    } div_cfg_t;
endpackage

// File: rtl/sdiv_cfg_hold.sv
// Settings capture: copies mode, idle level and divide value on every edge
// where enable is low, and holds them while enable is high. It also
// precomputes the clamped exponent for the exponential law.
// Assumes EXP_MAX fits in EXP_SEL_W bits.
module sdiv_cfg_hold
    import sdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             linear_in,
    input  logic             idle_in,
    input  logic [DIV_W-1:0] div_in,
    output div_cfg_t         cfg_q
);
    logic [EXP_SEL_W-1:0] exp_clamped;

    // Clamp the divide value to the legal exponent range.
    always_comb begin
        if (div_in > DIV_W'(EXP_MAX))
            exp_clamped = EXP_SEL_W'(EXP_MAX);
        else
            exp_clamped = div_in[EXP_SEL_W-1:0];
    end

    // Capture the settings only while the divider is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (!enable) begin
            cfg_q.linear    <= linear_in;
            cfg_q.idle_high <= idle_in;
            cfg_q.div       <= div_in;
            cfg_q.exp_n     <= exp_clamped;
        end
    end

    // R5: the captured settings do not move while the divider runs.
    assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(cfg_q));

    // R3: the exponent is either the saturated maximum or the low field bits.
    assert_exp_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.exp_n == EXP_SEL_W'(EXP_MAX)) ||
        (cfg_q.exp_n == cfg_q.div[EXP_SEL_W-1:0]));
endmodule

// File: rtl/sdiv_lin_timer.sv
// Linear half-period timer: a down counter that is preloaded while stopped,
// flags "due" at zero and then reloads with N. The flag therefore occurs
// every N+1 enabled cycles. Assumes load_val equals the value captured as
// run_val on the same edge.
module sdiv_lin_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] run_val,
    output logic         due
);
    logic [W-1:0] cnt_q;

    // Count down while running; preload from the raw field while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!enable)
            cnt_q <= load_val;
        else if (cnt_q == '0)
            cnt_q <= run_val;
        else
            cnt_q <= cnt_q - W'(1);
    end

    // Flag the last cycle of each half period.
    always_comb due = enable && (cnt_q == '0);

    // R1: the counter never exceeds the captured reload value while running.
    assert_lin_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (cnt_q <= run_val));

    // R8: each run starts from a full half period.
    assert_lin_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |-> (cnt_q == run_val));
endmodule

// File: rtl/sdiv_exp_timer.sv
// Exponential half-period timer: a free-running up counter, cleared while
// stopped. It flags "due" whenever its low sel bits are all ones, which
// happens every 2^sel enabled cycles. Assumes sel <= CNT_W.
module sdiv_exp_timer #(
    parameter int unsigned CNT_W = 15,
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    output logic             due
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    // Free-run while enabled; clear while stopped so a run starts at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // Build a mask of the low sel bits (wraps to all ones when sel == CNT_W).
    always_comb mask = (CNT_W'(1) << sel) - CNT_W'(1);

    // Flag the last cycle of each power-of-two half period.
    always_comb due = enable && ((cnt_q & mask) == mask);

    // R8: each run starts with the counter at zero.
    assert_exp_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |-> (cnt_q == '0));
endmodule

// File: rtl/sdiv_edge_gen.sv
// Edge generator: keeps the serial clock level, parks it at the idle level
// while stopped and flips it on each due cycle. It also classifies every
// flip as leading (leaving idle) or trailing (returning to idle).
// Assumes idle_q is the captured copy of idle_load.
module sdiv_edge_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic idle_load,
    input  logic idle_q,
    input  logic due,
    output logic sclk,
    output logic tick,
    output logic lead,
    output logic trail
);
    logic sclk_q;

    // Park at idle while stopped; flip on each due cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sclk_q <= 1'b0;
        else if (!enable)
            sclk_q <= idle_load;
        else if (due)
            sclk_q <= ~sclk_q;
    end

    // Classify the coming flip by the present level.
    always_comb begin
        tick  = due;
        lead  = due && (sclk_q == idle_q);
        trail = due && (sclk_q != idle_q);
        sclk  = sclk_q;
    end

    // R6: a stopped divider rests at the captured idle level.
    assert_idle_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (sclk_q == idle_q));

    // R7: a leading strobe moves the clock away from idle.
    assert_lead_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lead |=> (sclk_q != idle_q));

    // R7: a trailing strobe brings the clock back to idle.
    assert_trail_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trail |=> (sclk_q == idle_q));

    // R7: without a tick the running clock holds its level.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !due) |=> $stable(sclk_q));
endmodule

// File: rtl/sclk_div_dual.sv
// Top: dual-law serial clock divider. It captures the settings while
// stopped, runs a linear and an exponential timer side by side, selects one
// by the captured mode bit and turns the selected flag into clock edges and
// strobes. Assumes the settings inputs are synchronous to clk.
module sclk_div_dual
    import sdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_linear,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_idle_high,
    output logic             sclk,
    output logic             sclk_tick,
    output logic             lead_stb,
    output logic             trail_stb
);
    div_cfg_t cfg_q;
    logic     lin_due;
    logic     exp_due;
    logic     due;

    sdiv_cfg_hold u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .linear_in (cfg_linear),
        .idle_in   (cfg_idle_high),
        .div_in    (cfg_div),
        .cfg_q     (cfg_q)
    );

    sdiv_lin_timer #(.W(DIV_W)) u_lin (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .load_val (cfg_div),
        .run_val  (cfg_q.div),
        .due      (lin_due)
    );

    sdiv_exp_timer #(.CNT_W(EXP_CNT_W), .SEL_W(EXP_SEL_W)) u_exp (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .sel    (cfg_q.exp_n),
        .due    (exp_due)
    );

    // Pick the flag of the law chosen by the captured mode bit.
    always_comb due = cfg_q.linear ? lin_due : exp_due;

    sdiv_edge_gen u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .idle_load (cfg_idle_high),
        .idle_q    (cfg_q.idle_high),
        .due       (due),
        .sclk      (sclk),
        .tick      (sclk_tick),
        .lead      (lead_stb),
        .trail     (trail_stb)
    );
endmodule

// File: tb/sim_sclk_div_dual.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected strobes of each run into
// a queue, and the monitor pops and compares them as the design emits them.
module sim_sclk_div_dual;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cfg_linear = 1'b0;
    logic [7:0] cfg_div = '0;
    logic       cfg_idle_high = 1'b0;
    logic       sclk, sclk_tick, lead_stb, trail_stb;

    always #2.5 clk = ~clk;

    sclk_div_dual u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_linear(cfg_linear),
        .cfg_div(cfg_div), .cfg_idle_high(cfg_idle_high), .sclk(sclk),
        .sclk_tick(sclk_tick), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    typedef struct {
        int    at_rel;
        bit    is_lead;
        bit    level;
        string tag;
    } exp_item_t;

    exp_item_t q[$];
    exp_item_t e;
    int  errors = 0;
    int  checks = 0;
    bit  running = 1'b0;
    int  rel = 0;
    bit  done = 1'b0;

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Monitor: compare each strobe against the head of the queue.
    always @(negedge clk) begin
        if (running) begin
            if (lead_stb || trail_stb || sclk_tick) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R7 unexpected strobe at cycle %0d: got lead=%0b trail=%0b, expected none",
                             rel, lead_stb, trail_stb);
                end else begin
                    e = q.pop_front();
                    if (rel != e.at_rel || lead_stb != e.is_lead || trail_stb == e.is_lead ||
                        sclk_tick != 1'b1 || sclk != e.level) begin
                        errors++;
                        $display("FAIL %s/R7 strobe: got cycle=%0d lead=%0b trail=%0b sclk=%0b, expected cycle=%0d lead=%0b sclk=%0b",
                                 e.tag, rel, lead_stb, trail_stb, sclk, e.at_rel, e.is_lead, e.level);
                    end
                end
            end
            rel++;
        end else begin
            rel = 0;
            if (rst_n && (lead_stb || trail_stb || sclk_tick)) begin
                checks++;
                errors++;
                $display("FAIL R6 strobe while stopped: got %0b%0b%0b, expected 000",
                         sclk_tick, lead_stb, trail_stb);
            end
        end
    end

    // Driver: load settings while stopped, queue the expected edges, start.
    task automatic arm(input bit lin, input bit idle, input int div,
                       input int nedges, input string tag, output int half);
        @(posedge clk); #1;
        enable = 1'b0; running = 1'b0;
        cfg_linear = lin; cfg_div = 8'(div); cfg_idle_high = idle;
        repeat (2) @(posedge clk);
        #1;
        half = lin ? div + 1 : (1 << ((div > 15) ? 15 : div));
        for (int k = 0; k < nedges; k++) begin
            q.push_back('{(k + 1) * half - 1, (k % 2) == 0, idle ^ bit'(k % 2), tag});
        end
        enable = 1'b1; running = 1'b1;
    endtask

    // Driver: run a number of cycles, stop, confirm the queue drained and idle.
    task automatic close(input int cycles, input bit idle, input string tag);
        repeat (cycles) @(posedge clk);
        #1;
        enable = 1'b0; running = 1'b0;
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL %s missing strobes: got %0d pending, expected 0", tag, q.size());
            q.delete();
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (sclk != idle) begin
            errors++;
            $display("FAIL R6 idle level after stop: got %0b, expected %0b", sclk, idle);
        end
    endtask

    task automatic run_case(input bit lin, input bit idle, input int div,
                            input int nedges, input string tag);
        int half;
        arm(lin, idle, div, nedges, tag, half);
        close(nedges * half, idle, tag);
    endtask

    initial begin
        int half;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        checks++;
        if (sclk !== 1'b0 || sclk_tick !== 1'b0 || lead_stb !== 1'b0 || trail_stb !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset outputs: got %0b%0b%0b%0b, expected 0000",
                     sclk, sclk_tick, lead_stb, trail_stb);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;

        run_case(1'b1, 1'b0, 0,   4, "R4");   // linear, fastest
        run_case(1'b1, 1'b0, 3,   4, "R1");   // linear, half period 4
        run_case(1'b1, 1'b0, 255, 2, "R1");   // linear, largest field
        run_case(1'b0, 1'b0, 0,   4, "R4");   // exponential, fastest
        run_case(1'b0, 1'b0, 2,   4, "R2");   // exponential, half period 4
        run_case(1'b0, 1'b1, 5,   3, "R9");   // exponential, idle high
        run_case(1'b1, 1'b1, 7,   3, "R9");   // linear, idle high
        run_case(1'b0, 1'b0, 200, 2, "R3");   // clamped to 2^15

        // R5: settings changed mid-run are ignored
        arm(1'b1, 1'b0, 1, 4, "R5", half);
        repeat (3) @(posedge clk);
        #1;
        cfg_linear = 1'b0; cfg_div = 8'd9; cfg_idle_high = 1'b1;
        repeat (4 * half - 3) @(posedge clk);
        #1;
        cfg_linear = 1'b1; cfg_div = 8'd1; cfg_idle_high = 1'b0;
        close(0, 1'b0, "R5");

        // R8: stop in mid-period, then restart from a full half period
        arm(1'b1, 1'b0, 5, 1, "R8", half);
        close(8, 1'b0, "R8");
        run_case(1'b1, 1'b0, 5, 2, "R8");

        done = 1'b1;
        report();
        $finish;
    end

    // Watchdog: an overlong run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            report();
            $finish;
        end
    end
endmodule